// File: doc/BRIEF.md
# Recirculating Delay-Line Word Memory

This block is a small serial word store built from closed recirculating loops. There are W loops, one per bit of a word, and each loop holds N bit positions. Every clock, each loop's regeneration flop reloads from the loop's output end, so the contents circulate with no outside action. All loops move in lockstep, so together they behave like N words of W bits. A slot counter follows which word position is passing the output end at any moment.

A read or write request names a slot. It is latched and then waits until that slot rotates to the regeneration point. On that cycle the whole word moves across all loops at once: a write forces the regeneration flops to the new word, and a read captures the output taps while the loops keep circulating. Access latency therefore depends on where the target slot sits relative to the current position, from 1 to N clocks. A one-cycle done strobe marks completion.

Top module: `dlm_top`

## Requirements
- R1: A synchronous active-low reset clears the slot counter, every stored bit, `rd_data` and `done`. After reset, every slot reads back as zero.
- R2: The slot counter starts at 0 on the first clock after reset. It advances by one on every clock and wraps from N-1 to 0.
- R3: A request is accepted on a clock edge while no access is pending. Let m be the counter value in the cycle after acceptance. `done` is then high for exactly one cycle, ((slot - m) mod N) + 1 clocks after acceptance, so latency runs from 1 to N clocks.
- R4: A write stores `wr_data` in the named slot and leaves all other slots unchanged. A later read of that slot returns the word on `rd_data` in the `done` cycle.
- R5: Stored words are retained indefinitely without any access.
- R6: A read does not alter stored contents, so a repeated read returns the same word.
- R7: A request that arrives while another access is pending is ignored. It does not change any slot and produces no extra `done`.
- R8: If `wr_req` and `rd_req` are high on the same accepting edge, only the write is served. `rd_data` changes only when a read completes and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | Write request, sampled on the clock edge |
| wr_addr | input | AW | Slot to write |
| wr_data | input | W | Word to write |
| rd_req | input | 1 | Read request, sampled on the clock edge |
| rd_addr | input | AW | Slot to read |
| rd_data | output | W | Word captured by the last completed read |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench targets the latency extremes. A slot reached on the very next clock tests an off-by-one in the slot compare, and the full N-clock wait tests a design that fires at acceptance time. A design that lost the slot-to-position mapping would put a written word into the wrong slot, which the bench sees on readback against its reference array. A request injected while another is pending, and a read paired with a write, catch designs that overwrite the latched access or update `rd_data` on a write.

// File: rtl/dlm_pkg.sv
// Package: shared types for the recirculating delay-line memory.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package dlm_pkg;
    // Kind of access currently latched by the controller.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/dlm_slot_counter.sv
// Slot counter: tracks which word position is at the loop output end.
// Assumes N >= 2; counts 0..N-1 and wraps, cleared by synchronous reset.
module dlm_slot_counter #(
    parameter int N  = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] slot_o
);
    localparam logic [AW-1:0] LAST = AW'(N - 1);

    logic [AW-1:0] slot_q;

    // Advance one position per clock, wrapping at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_q <= '0;
        else if (slot_q == LAST)
            slot_q <= '0;
        else
            slot_q <= slot_q + AW'(1);
    end

    assign slot_o = slot_q;
endmodule

// File: rtl/dlm_loop_line.sv
// One recirculating loop of N bit positions.
// stage_q[0] is the regeneration flop; stage_q[N-1] is the output end.
// Assumes N >= 2. A force pulse replaces the recirculated bit.
module dlm_loop_line #(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_i,
    input  logic force_bit_i,
    output logic tap_o
);
    logic [N-1:0] stage_q;
    logic         regen_d;

    // Choose what the regeneration flop takes this clock.
    always_comb begin
        regen_d = force_i ? force_bit_i : stage_q[N-1];
    end

    // Shift the loop by one position; the regeneration flop closes it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= '0;
        else
            stage_q <= {stage_q[N-2:0], regen_d};
    end

    assign tap_o = stage_q[N-1];
endmodule

// File: rtl/dlm_access_ctrl.sv
// Access controller: latches one request, waits for its slot, fires.
// Assumes the slot input is the position currently at the output end.
// Only one access is held; new requests are dropped while one waits.
module dlm_access_ctrl
    import dlm_pkg::*;
#(
    parameter int N  = 8,
    parameter int W  = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [W-1:0]  wr_data_i,
    input  logic          rd_req_i,
    input  logic [AW-1:0] rd_addr_i,
    input  logic [AW-1:0] slot_i,
    output logic          wr_fire_o,
    output logic          rd_fire_o,
    output logic [W-1:0]  wr_word_o,
    output logic          pending_o,
    output logic          done_o
);
    acc_kind_e     kind_q;
    logic [AW-1:0] addr_q;
    logic [W-1:0]  word_q;
    logic          done_q;
    logic          accept;
    logic          hit;

    // Decode acceptance of a new request and arrival of the target slot.
    always_comb begin
        accept = (kind_q == ACC_IDLE) && (wr_req_i || rd_req_i);
        hit    = (kind_q != ACC_IDLE) && (slot_i == addr_q);
    end

    // Hold the pending access and raise done after it completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= ACC_IDLE;
            addr_q <= '0;
            word_q <= '0;
            done_q <= 1'b0;
        end else if (hit) begin
            kind_q <= ACC_IDLE;
            done_q <= 1'b1;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                kind_q <= wr_req_i ? ACC_WRITE : ACC_READ;
                addr_q <= wr_req_i ? wr_addr_i : rd_addr_i;
                word_q <= wr_data_i;
            end
        end
    end

    assign wr_fire_o = hit && (kind_q == ACC_WRITE);
    assign rd_fire_o = hit && (kind_q == ACC_READ);
    assign wr_word_o = word_q;
    assign pending_o = (kind_q != ACC_IDLE);
    assign done_o    = done_q;
endmodule

// File: rtl/dlm_top.sv
// Top: W lockstep loops of N positions, a slot counter, one controller.
// Assumes N >= 2. Writes force all regeneration flops in the slot's
// cycle; reads capture the output taps into rd_data in the same cycle.
module dlm_top #(
    parameter int N  = 8,
    parameter int W  = 8,
    parameter int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    output logic          done
);
    logic [AW-1:0] slot_q;
    logic          wr_fire;
    logic          rd_fire;
    logic [W-1:0]  wr_word;
    logic          pending;
    logic [W-1:0]  taps;
    logic [W-1:0]  rd_q;

    dlm_slot_counter #(.N(N), .AW(AW)) slot_ctr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_o (slot_q)
    );

    dlm_access_ctrl #(.N(N), .W(W), .AW(AW)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req_i  (wr_req),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_req_i  (rd_req),
        .rd_addr_i (rd_addr),
        .slot_i    (slot_q),
        .wr_fire_o (wr_fire),
        .rd_fire_o (rd_fire),
        .wr_word_o (wr_word),
        .pending_o (pending),
        .done_o    (done)
    );

    // One loop per word bit, all driven by the same force pulse.
    for (genvar g = 0; g < W; g++) begin : g_line
        dlm_loop_line #(.N(N)) line_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .force_i     (wr_fire),
            .force_bit_i (wr_word[g]),
            .tap_o       (taps[g])
        );
    end

    // Capture the passing word when a read reaches its slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (rd_fire)
            rd_q <= taps;
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/dlm_top_chk.sv
// Checker for dlm_top, attached by bind. Observes the counter, the
// pending flag and the outputs; drives nothing.
module dlm_top_chk #(
    parameter int N  = 8,
    parameter int W  = 8,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] slot_q,
    input logic          pending,
    input logic          done,
    input logic [W-1:0]  rd_data
);
    localparam logic [AW-1:0] LAST = AW'(N - 1);

    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == LAST) |=> (slot_q == '0)); // R2
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q != LAST) |=> (slot_q == $past(slot_q) + AW'(1))); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_DONE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(pending)); // R3
    AST_DONE_CLEARS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !pending); // R7
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> done); // R8
endmodule

bind dlm_top dlm_top_chk #(.N(N), .W(W), .AW(AW)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot_q  (slot_q),
    .pending (pending),
    .done    (done),
    .rd_data (rd_data)
);

// File: tb/dlm_top_tb_top.sv
`timescale 1ns/1ps
module dlm_top_tb_top;
    localparam int N  = 8;
    localparam int W  = 8;
    localparam int AW = 3;
    // Vector: bit 12 = 1 write / 0 read, [11:8] slot, [7:0] write data.
    localparam logic [15:0] VEC [12] = '{
        16'h1_0_11, 16'h1_7_E2, 16'h1_3_5A, 16'h0_3_00,
        16'h0_7_00, 16'h1_0_FF, 16'h0_0_00, 16'h1_4_81,
        16'h0_1_00, 16'h1_1_0F, 16'h0_4_00, 16'h0_1_00
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_req = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic          rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [W-1:0]  rd_data;
    logic          done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int bcnt = 0;
    logic [W-1:0] ref_mem [N];
    logic [W-1:0] last_rd = '0;

    always #4 clk = ~clk;

    // Bench copy of the slot position, built from R2 alone.
    always @(posedge clk) begin
        if (!rst_n) bcnt <= 0;
        else        bcnt <= (bcnt + 1) % N;
    end

    dlm_top #(.N(N), .W(W), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_data(rd_data), .done(done)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One access; optionally injects a write while pending (R7).
    task automatic access(input bit w, input bit r, input int wa,
                          input logic [W-1:0] wd, input int ra,
                          input bit inj, input int ia,
                          input logic [W-1:0] id, input string tag);
        int target;
        int m;
        int lat;
        bit early;
        target = w ? wa : ra;
        wr_req = w; wr_addr = AW'(wa); wr_data = wd;
        rd_req = r; rd_addr = AW'(ra);
        @(negedge clk);
        m = bcnt;
        wr_req = 1'b0; rd_req = 1'b0;
        lat = ((target - m + N) % N) + 1;
        early = 1'b0;
        for (int i = 1; i <= lat; i++) begin
            if (done) early = 1'b1;
            if (inj && i == 1) begin
                wr_req = 1'b1; wr_addr = AW'(ia); wr_data = id;
            end else begin
                wr_req = 1'b0;
            end
            @(negedge clk);
        end
        wr_req = 1'b0;
        check(!early, {tag, " R3 no early done"}, 32'(early), 0);
        check(done == 1'b1, {tag, " R3 done at slot"}, 32'(done), 1);
        if (w) begin
            ref_mem[wa] = wd;
            check(rd_data == last_rd, {tag, " R8 rd_data held on write"},
                  32'(rd_data), 32'(last_rd));
        end else begin
            check(rd_data == ref_mem[ra], {tag, " R4 read data"},
                  32'(rd_data), 32'(ref_mem[ra]));
            last_rd = rd_data;
        end
        @(negedge clk);
        check(done == 1'b0, {tag, " R3 done one cycle"}, 32'(done), 0);
    endtask

    task automatic read_all(input string tag);
        for (int s = 0; s < N; s++)
            access(1'b0, 1'b1, 0, '0, s, 1'b0, 0, '0, tag);
    endtask

    initial begin
        for (int s = 0; s < N; s++) ref_mem[s] = '0;
        repeat (4) @(negedge clk);
        check(done == 1'b0, "R1 done in reset", 32'(done), 0);
        check(rd_data == '0, "R1 rd_data in reset", 32'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        read_all("R1 slots zero after reset");

        // Table walk (R4, R2 via latency).
        for (int v = 0; v < 12; v++)
            access(VEC[v][12], !VEC[v][12], int'(VEC[v][11:8]), VEC[v][7:0],
                   int'(VEC[v][11:8]), 1'b0, 0, '0, "R4 vector");

        // Retention with no access (R5).
        repeat (300) @(negedge clk);
        read_all("R5 retention");

        // Repeated read leaves contents unchanged (R6).
        access(1'b0, 1'b1, 0, '0, 7, 1'b0, 0, '0, "R6 read 1");
        access(1'b0, 1'b1, 0, '0, 7, 1'b0, 0, '0, "R6 read 2");

        // Request during pending is dropped (R7).
        access(1'b1, 1'b0, 2, 8'hA5, 0, 1'b1, 6, 8'h3C, "R7 base write");
        access(1'b0, 1'b1, 0, '0, 6, 1'b0, 0, '0, "R7 slot 6 untouched");
        access(1'b0, 1'b1, 0, '0, 2, 1'b0, 0, '0, "R7 slot 2 written");

        // Write wins over a simultaneous read (R8).
        access(1'b1, 1'b1, 5, 8'h77, 3, 1'b0, 0, '0, "R8 both");
        access(1'b0, 1'b1, 0, '0, 5, 1'b0, 0, '0, "R8 write landed");

        // Latency extremes: N clocks and 1 clock (R2, R3).
        access(1'b0, 1'b1, 0, '0, bcnt, 1'b0, 0, '0, "R2 R3 worst case");
        access(1'b1, 1'b0, (bcnt + 1) % N, 8'hC3, 0, 1'b0, 0, '0, "R3 next slot");
        read_all("R4 final sweep");

        // Reset again clears everything (R1).
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(rd_data == '0, "R1 rd_data after re-reset", 32'(rd_data), 0);
        rst_n = 1'b1;
        for (int s = 0; s < N; s++) ref_mem[s] = '0;
        last_rd = '0;
        @(negedge clk);
        read_all("R1 cleared after re-reset");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule